// File: doc/BRIEF.md
# Sliding Window Packet Qualifier

This block turns a stream of per-packet verdicts into a debounced, active-low detect line. Upstream logic measures each packet of the incoming tone and raises a one-cycle strobe, with a flag that says whether the packet was good. The qualifier keeps the most recent packet verdicts in a sliding window. Every strobe shifts the window by one packet and evaluates it again. The detect line asserts once the good packets in the window reach a threshold. It releases once the bad packets in the window reach the same threshold. Between these two points the line holds its state, so short fades during a tone and short bursts during silence leave it unchanged.

A system-select input chooses between two operating systems, each with its own window length and threshold. The high-frequency system (select low) uses a 24-packet window with a threshold of 20. The low-frequency system (select high) uses an 18-packet window with a threshold of 15. When the select changes, the window is cleared to all-bad and the line is forced to not-detect. Packets arriving back to back therefore produce a response after 20 (or 15) packets. Cumulative packets spread over the window also qualify, provided the window still holds enough of them.

Top module: `pkt_window_qual`

## Requirements
- R1: While `rst` is high at a clock edge, `det_n` becomes 1 (not detect) and the window is emptied to all-bad (good count 0).
- R2: With `sys_sel`=0, the window holds the last 24 strobed packets. On the clock edge of the strobe that brings the good count in the window to 20, `det_n` becomes 0. Good packets need not be consecutive.
- R3: With `sys_sel`=0, on the clock edge of the strobe that brings the bad count in the window to 20 (good count 4 or less), `det_n` becomes 1.
- R4: With `sys_sel`=1, the window holds the last 18 strobed packets. Detect occurs at 15 good packets. Release occurs at 15 bad packets (good count 3 or less).
- R5: While the good count stays strictly between the release point and the detect point, `det_n` keeps its value. Isolated bad packets inside a tone and short good bursts inside silence therefore do not change it.
- R6: `pkt_good` has no effect while `pkt_valid` is 0, and `det_n` changes only at a strobe, a reset or a change of `sys_sel`.
- R7: On the first clock edge at which `sys_sel` differs from its value at the previous edge, the window is cleared to all-bad and `det_n` becomes 1. Any strobe presented at that edge is dropped.
- R8: A packet that leaves the window no longer counts. After 19 good packets followed by a full window of bad packets, a further 19 good packets do not assert `det_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_sel | input | 1 | System select: 0 = 24-packet system, 1 = 18-packet system |
| pkt_valid | input | 1 | One-cycle strobe marking the end of a measured packet |
| pkt_good | input | 1 | Verdict of the strobed packet: 1 = good tone, 0 = bad or no tone |
| det_n | output | 1 | Registered packet-mode detect, active low |

## Verification
The bench builds the block with its default parameters: a 24-packet window with threshold 20, and an 18-packet window with threshold 15. Since a packet costs only two clock cycles, a few hundred strobes reach both detect points and both release points in each system. They also reach the hold band in between, where fade and burst patterns should leave the output unchanged. A full window roll-over, which shows that old verdicts drop out, and a system switch in the middle of a tone with a strobe in the switching cycle also fit in that budget.

// File: rtl/pwq_pkg.sv
package pwq_pkg;

  typedef enum logic {
    SYS_WIDE   = 1'b0,
    SYS_NARROW = 1'b1
  } sys_mode_e;

  function automatic int unsigned imax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pwq_window.sv
module pwq_window #(
  parameter int unsigned WIN_WIDE   = 24,
  parameter int unsigned WIN_NARROW = 18,
  parameter int unsigned DEPTH      = pwq_pkg::imax(WIN_WIDE, WIN_NARROW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              shift,
  input  logic              bit_in,
  input  pwq_pkg::sys_mode_e mode,
  output logic              bit_out
);

  logic [DEPTH-1:0] hist_q;
  logic             tap_wide;
  logic             tap_narrow;

  // Oldest verdict of each window length: the one about to leave
  assign tap_wide   = hist_q[WIN_WIDE-1];
  assign tap_narrow = hist_q[WIN_NARROW-1];

  always_comb begin
    if (mode == pwq_pkg::SYS_NARROW) bit_out = tap_narrow;
    else                             bit_out = tap_wide;
  end

  generate
    if (DEPTH > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst || clr)  hist_q <= '0;
        else if (shift)  hist_q <= {hist_q[DEPTH-2:0], bit_in};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst || clr)  hist_q <= '0;
        else if (shift)  hist_q <= bit_in;
      end
    end
  endgenerate

endmodule

// File: rtl/pwq_tally.sv
module pwq_tally #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  input  logic          add,
  input  logic          sub,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_next
);

  logic [CW-1:0] cnt_q;

  assign cnt = cnt_q;

  always_comb begin
    cnt_next = cnt_q;
    if (step) cnt_next = cnt_q + CW'(add) - CW'(sub);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else            cnt_q <= cnt_next;
  end

endmodule

// File: rtl/pwq_decide.sv
module pwq_decide #(
  parameter int unsigned CW         = 5,
  parameter int unsigned WIN_WIDE   = 24,
  parameter int unsigned THR_WIDE   = 20,
  parameter int unsigned WIN_NARROW = 18,
  parameter int unsigned THR_NARROW = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               step,
  input  logic [CW-1:0]      cnt_next,
  input  pwq_pkg::sys_mode_e mode,
  output logic               det_n
);

  localparam logic [CW-1:0] ON_WIDE    = CW'(THR_WIDE);
  localparam logic [CW-1:0] OFF_WIDE   = CW'(WIN_WIDE - THR_WIDE);
  localparam logic [CW-1:0] ON_NARROW  = CW'(THR_NARROW);
  localparam logic [CW-1:0] OFF_NARROW = CW'(WIN_NARROW - THR_NARROW);

  logic [CW-1:0] on_lvl;
  logic [CW-1:0] off_lvl;
  logic          det_n_q;

  always_comb begin
    if (mode == pwq_pkg::SYS_NARROW) begin
      on_lvl  = ON_NARROW;
      off_lvl = OFF_NARROW;
    end else begin
      on_lvl  = ON_WIDE;
      off_lvl = OFF_WIDE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      det_n_q <= 1'b1;
    end else if (step) begin
      if (cnt_next >= on_lvl)       det_n_q <= 1'b0;
      else if (cnt_next <= off_lvl) det_n_q <= 1'b1;
    end
  end

  assign det_n = det_n_q;

endmodule

// File: rtl/pkt_window_qual.sv
module pkt_window_qual #(
  parameter int unsigned WIN_WIDE   = 24,
  parameter int unsigned THR_WIDE   = 20,
  parameter int unsigned WIN_NARROW = 18,
  parameter int unsigned THR_NARROW = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic sys_sel,
  input  logic pkt_valid,
  input  logic pkt_good,
  output logic det_n
);

  localparam int unsigned DEPTH = pwq_pkg::imax(WIN_WIDE, WIN_NARROW);
  localparam int unsigned CW    = $clog2(DEPTH + 1);

  logic               sys_q;
  logic               sys_flip;
  logic               step;
  logic               leaving;
  logic [CW-1:0]      good_cnt;
  logic [CW-1:0]      good_next;
  pwq_pkg::sys_mode_e mode;

  always_ff @(posedge clk) begin
    sys_q <= sys_sel;
  end

  assign sys_flip = !rst && (sys_sel != sys_q);
  assign step     = pkt_valid && !sys_flip;
  assign mode     = pwq_pkg::sys_mode_e'(sys_q);

  pwq_window #(
    .WIN_WIDE   (WIN_WIDE),
    .WIN_NARROW (WIN_NARROW),
    .DEPTH      (DEPTH)
  ) u_window (
    .clk     (clk),
    .rst     (rst),
    .clr     (sys_flip),
    .shift   (step),
    .bit_in  (pkt_good),
    .mode    (mode),
    .bit_out (leaving)
  );

  pwq_tally #(
    .CW (CW)
  ) u_tally (
    .clk      (clk),
    .rst      (rst),
    .clr      (sys_flip),
    .step     (step),
    .add      (pkt_good),
    .sub      (leaving),
    .cnt      (good_cnt),
    .cnt_next (good_next)
  );

  pwq_decide #(
    .CW         (CW),
    .WIN_WIDE   (WIN_WIDE),
    .THR_WIDE   (THR_WIDE),
    .WIN_NARROW (WIN_NARROW),
    .THR_NARROW (THR_NARROW)
  ) u_decide (
    .clk      (clk),
    .rst      (rst),
    .clr      (sys_flip),
    .step     (step),
    .cnt_next (good_next),
    .mode     (mode),
    .det_n    (det_n)
  );

endmodule

// File: rtl/pwq_checks.sv
module pwq_checks #(
  parameter int unsigned CW         = 5,
  parameter int unsigned WIN_WIDE   = 24,
  parameter int unsigned WIN_NARROW = 18
) (
  input logic          clk,
  input logic          rst,
  input logic          sys_sel,
  input logic          sys_q,
  input logic          pkt_valid,
  input logic          pkt_good,
  input logic          det_n,
  input logic [CW-1:0] good_cnt
);

  // R1: reset always leaves the line at not-detect
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> det_n);

  // R6: no strobe and no system change means the line holds
  assert_hold_no_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    (!pkt_valid && $stable(sys_sel)) |=> $stable(det_n));

  // R7: a system change forces not-detect
  assert_switch_clears_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(sys_sel) |=> det_n);

  // R2: detect can only start on a good strobe
  assert_detect_on_good_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(det_n) |-> $past(pkt_valid && pkt_good));

  // R3: release by packets only follows a bad strobe (or a system change)
  assert_release_on_bad_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(det_n) && $past(sys_sel) == $past(sys_q)) |-> $past(pkt_valid && !pkt_good));

  // R4: the good count never exceeds the active window length
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    good_cnt <= CW'(sys_q ? WIN_NARROW : WIN_WIDE));

endmodule

bind pkt_window_qual pwq_checks #(
  .CW         (CW),
  .WIN_WIDE   (WIN_WIDE),
  .WIN_NARROW (WIN_NARROW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sys_sel   (sys_sel),
  .sys_q     (sys_q),
  .pkt_valid (pkt_valid),
  .pkt_good  (pkt_good),
  .det_n     (det_n),
  .good_cnt  (good_cnt)
);

// File: tb/pkt_window_qual_bench.sv
module pkt_window_qual_bench;

  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sys_sel = 1'b0;
  logic pkt_valid = 1'b0;
  logic pkt_good = 1'b0;
  logic det_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pkt_window_qual u_pkt_window_qual (
    .clk       (clk),
    .rst       (rst),
    .sys_sel   (sys_sel),
    .pkt_valid (pkt_valid),
    .pkt_good  (pkt_good),
    .det_n     (det_n)
  );

  task automatic chk(input logic exp, input string req);
    n_chk++;
    if (det_n !== exp) begin
      n_bad++;
      $display("FAIL %s: det_n=%b expected %b at %0t", req, det_n, exp, $time);
    end
  endtask

  task automatic do_reset(input logic sel);
    @(negedge clk);
    sys_sel = sel; rst = 1'b1; pkt_valid = 1'b0; pkt_good = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send_pkt(input logic g);
    @(negedge clk);
    pkt_valid = 1'b1; pkt_good = g;
    @(negedge clk);
    pkt_valid = 1'b0; pkt_good = 1'b0;
  endtask

  task automatic send_run(input int n, input logic g);
    for (int i = 0; i < n; i++) send_pkt(g);
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    chk(1'b1, "R1 reset state");
  endtask

  task automatic t_assert_wide;
    do_reset(1'b0);
    send_run(18, 1'b1);
    send_pkt(1'b0);                       // count 18, window holds one bad
    send_pkt(1'b1);                       // count 19
    chk(1'b1, "R2 19 good of 24");
    // R6: good flag without strobe must be ignored
    @(negedge clk); pkt_good = 1'b1;
    for (int i = 0; i < 10; i++) @(negedge clk);
    pkt_good = 1'b0;
    chk(1'b1, "R6 pkt_good without strobe");
    send_pkt(1'b1);                       // count 20, cumulative
    chk(1'b0, "R2 20th good packet");
  endtask

  task automatic t_release_wide;
    do_reset(1'b0);
    send_run(24, 1'b1);
    chk(1'b0, "R2 full good window");
    send_run(19, 1'b0);                   // good count 5
    chk(1'b0, "R5 19 bad of 24 still detect");
    send_pkt(1'b0);                       // good count 4
    chk(1'b1, "R3 20th bad packet releases");
  endtask

  task automatic t_fade_burst;
    do_reset(1'b0);
    send_run(24, 1'b1);
    for (int k = 0; k < 12; k++) begin     // fades: 1 bad in every 4
      send_pkt(1'b0);
      send_run(3, 1'b1);
      if (k == 5 || k == 11) chk(1'b0, "R5 fades ignored");
    end
    do_reset(1'b0);
    for (int k = 0; k < 3; k++) begin     // bursts of 12 good
      send_run(12, 1'b1);
      chk(1'b1, "R5 burst ignored");
      send_run(12, 1'b0);
    end
    chk(1'b1, "R5 after bursts");
  endtask

  task automatic t_slide;
    do_reset(1'b0);
    send_run(19, 1'b1);
    send_run(24, 1'b0);
    send_run(19, 1'b1);
    chk(1'b1, "R8 old packets forgotten");
    send_pkt(1'b1);
    chk(1'b0, "R8 fresh 20th good");
  endtask

  task automatic t_narrow;
    do_reset(1'b1);
    send_run(14, 1'b1);
    chk(1'b1, "R4 14 good of 18");
    send_pkt(1'b1);
    chk(1'b0, "R4 15th good detects");
    send_run(3, 1'b1);
    send_run(14, 1'b0);                   // good count 4
    chk(1'b0, "R4 14 bad holds");
    send_pkt(1'b0);                       // good count 3
    chk(1'b1, "R4 15th bad releases");
  endtask

  task automatic t_switch;
    do_reset(1'b0);
    send_run(24, 1'b1);
    chk(1'b0, "R7 detect before switch");
    @(negedge clk);
    sys_sel = 1'b1; pkt_valid = 1'b1; pkt_good = 1'b1;
    @(negedge clk);
    pkt_valid = 1'b0; pkt_good = 1'b0;
    chk(1'b1, "R7 switch forces not-detect");
    send_run(14, 1'b1);
    chk(1'b1, "R7 window cleared and strobe dropped");
    send_pkt(1'b1);
    chk(1'b0, "R7 15 good after switch");
  endtask

  initial begin
    t_reset();
    t_assert_wide();
    t_release_wide();
    t_fade_burst();
    t_slide();
    t_narrow();
    t_switch();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule